// File: doc/BRIEF.md
# Receive Fragment DMA Ring Manager

This block takes frames from a receive MAC front end as a byte stream (valid, byte, last-byte flag) and places them into memory buffers. The buffers are listed in a ring of descriptors that software keeps in memory. Each descriptor is two 32-bit words. Word 0 is the byte address of the buffer. Word 1 is control: bits [10:0] hold the buffer size minus one, and bit 31 asks for an interrupt. A frame larger than one buffer continues in the next descriptor's buffer. Every buffer that is used gets one 32-bit status word. Status bit 31 marks the last fragment of a frame, and bits [10:0] hold the number of bytes written minus one. All other status bits are zero.

Software sets the descriptor array base, the status array base, the ring count, the consume index and an enable bit. The block fetches a batch of descriptors through a burst-read port. It announces the matching status burst, writes frame bytes one at a time and writes each status word in the same cycle as the byte that completes its fragment. The block has no input buffering. The source must therefore space its bytes further apart than a descriptor refill takes, which is about 2·CACHE+3 cycles.

Top module: `rx_frag_dma`

## Requirements
- R1: After reset, prod_idx is 0, irq and overrun are 0, and no read, write or status request is active.
- R2: A fetch raises rd_req for one cycle. rd_addr is desc_base + 8·prod_idx. rd_len is 2·n−1, where n = min(free, ring_cnt − prod_idx, CACHE) and free = (cons_idx − prod_idx − 1) mod ring_cnt. For a 4-entry ring with both indices at 0, rd_len is 5.
- R3: In the same cycle as rd_req, st_cmd is raised with st_cmd_addr = stat_base + 4·prod_idx and st_cmd_len = n−1.
- R4: Each accepted byte appears on dw_valid/dw_byte at the current buffer address plus the byte's offset in that fragment.
- R5: When a buffer fills before the frame ends, the block writes status {last=0, level=size field} and continues the frame in the next descriptor's buffer.
- R6: The final fragment of a frame gets status bit 31 set and level = bytes written − 1. A 19-byte frame in 8-byte buffers gives levels 7, 7 and 2.
- R7: A status word goes to stat_base + 4·(descriptor index). st_we is asserted in the same cycle as the byte that closes the fragment.
- R8: prod_idx steps by one after each status write, wraps from ring_cnt−1 to 0, and does not change at any other time.
- R9: irq pulses for one cycle, in the cycle after the status write of a descriptor whose control bit 31 is set.
- R10: No fetch is issued while en is 0. A frame already in progress when en rises is dropped whole, and reception starts with the next frame.
- R11: If a byte of an accepted frame finds no loaded descriptor, the block drops the rest of that frame and sets overrun. Overrun stays set until ovr_clr is pulsed.
- R12: A size field of 0 gives a one-byte fragment. A frame that ends exactly on a buffer boundary writes exactly one status word (last set), and the next frame starts in the next descriptor.
- R13: No fetch is issued while the ring is full, that is, while prod_idx equals cons_idx−1 mod ring_cnt. A fetch follows once cons_idx moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receive enable |
| desc_base | input | 32 | Byte address of descriptor 0 |
| stat_base | input | 32 | Byte address of status word 0 |
| ring_cnt | input | IW | Number of descriptors in the ring |
| cons_idx | input | IW | Software consume index |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_valid | input | 1 | Byte present on rx_byte |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rd_req | output | 1 | Starts a descriptor burst read |
| rd_addr | output | 32 | Burst start address |
| rd_len | output | LW | Burst beats minus one |
| rd_rvalid | input | 1 | Read beat valid |
| rd_rdata | input | 32 | Read beat data |
| st_cmd | output | 1 | Announces a status burst |
| st_cmd_addr | output | 32 | Status burst start address |
| st_cmd_len | output | LW | Status words minus one |
| dw_valid | output | 1 | Frame byte write |
| dw_addr | output | 32 | Frame byte address |
| dw_byte | output | 8 | Frame byte data |
| st_we | output | 1 | Status word write |
| st_addr | output | 32 | Status word address |
| st_data | output | 32 | Status word |
| prod_idx | output | IW | Produce index |
| irq | output | 1 | Interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong offset counter or descriptor pointer shows up at once on dw_addr for the next byte, and on the level field of the status word that closes the fragment. Wrong index arithmetic appears on prod_idx in the cycle after a status write. It also appears on rd_addr and rd_len of the next fetch, which comes one cycle after the last cached descriptor is used, or it shows as a fetch that is missing or should not occur. A wrong enable or drop state is visible within one frame, as byte writes that should not occur, writes that are missing, or a change in overrun.

// File: rtl/rx_frag_dma.sv
module rx_frag_dma #(
  parameter int IW = 4,
  parameter int CACHE = 4,
  localparam int HW = $clog2(CACHE),
  localparam int CW = $clog2(CACHE + 1),
  localparam int LW = $clog2(2 * CACHE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [31:0]   desc_base,
  input  logic [31:0]   stat_base,
  input  logic [IW-1:0] ring_cnt,
  input  logic [IW-1:0] cons_idx,
  input  logic          ovr_clr,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  output logic          rd_req,
  output logic [31:0]   rd_addr,
  output logic [LW-1:0] rd_len,
  input  logic          rd_rvalid,
  input  logic [31:0]   rd_rdata,
  output logic          st_cmd,
  output logic [31:0]   st_cmd_addr,
  output logic [LW-1:0] st_cmd_len,
  output logic          dw_valid,
  output logic [31:0]   dw_addr,
  output logic [7:0]    dw_byte,
  output logic          st_we,
  output logic [31:0]   st_addr,
  output logic [31:0]   st_data,
  output logic [IW-1:0] prod_idx,
  output logic          irq,
  output logic          overrun
);

  logic [IW-1:0] prod_q;
  logic [CW-1:0] head_q, avail_q, ncl_q;
  logic [LW-1:0] bc_q;
  logic          fetching_q, mid_q, tk_q, drop_q, irq_q, ovr_q;
  logic [10:0]   off_q;

  logic [31:0] ca_addr [CACHE];
  logic [10:0] ca_size [CACHE];
  logic        ca_int  [CACHE];

  logic [IW:0] fr, te, nc;
  logic [CW-1:0] nc_s;

  always_comb begin
    fr = {1'b0, cons_idx} + {1'b0, ring_cnt} - {1'b0, prod_q} - (IW+1)'(1);
    if (fr >= {1'b0, ring_cnt}) fr = fr - {1'b0, ring_cnt};
    te = {1'b0, ring_cnt} - {1'b0, prod_q};
    nc = (fr < te) ? fr : te;
    if (nc > (IW+1)'(CACHE)) nc = (IW+1)'(CACHE);
  end
  assign nc_s = CW'(nc);

  logic [HW-1:0] cur;
  logic have, start, inframe, store, lose, fill, close, fire, last_beat;

  assign cur       = head_q[HW-1:0];
  assign have      = !fetching_q && (head_q != avail_q);
  assign start     = rx_valid && en && !mid_q;
  assign inframe   = start || (rx_valid && tk_q && !drop_q);
  assign store     = inframe && have;
  assign lose      = inframe && !have;
  assign fill      = (off_q == ca_size[cur]);
  assign close     = store && (fill || rx_last);
  assign fire      = en && !fetching_q && (head_q == avail_q)
                     && (ring_cnt != '0) && (fr != '0);
  assign last_beat = (bc_q == LW'(2 * int'(ncl_q) - 1));

  assign rd_req      = fire;
  assign rd_addr     = desc_base + (32'(prod_q) << 3);
  assign rd_len      = LW'(2 * int'(nc_s) - 1);
  assign st_cmd      = fire;
  assign st_cmd_addr = stat_base + (32'(prod_q) << 2);
  assign st_cmd_len  = LW'(int'(nc_s) - 1);
  assign dw_valid    = store;
  assign dw_addr     = ca_addr[cur] + 32'(off_q);
  assign dw_byte     = rx_byte;
  assign st_we       = close;
  assign st_addr     = stat_base + (32'(prod_q) << 2);
  assign st_data     = {rx_last, 20'd0, off_q};
  assign prod_idx    = prod_q;
  assign irq         = irq_q;
  assign overrun     = ovr_q;

  always_ff @(posedge clk) begin
    if (rd_rvalid && fetching_q) begin
      if (!bc_q[0]) ca_addr[bc_q[LW-1:1]] <= rd_rdata;
      else begin
        ca_size[bc_q[LW-1:1]] <= rd_rdata[10:0];
        ca_int[bc_q[LW-1:1]]  <= rd_rdata[31];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching_q <= 1'b0;
      head_q     <= '0;
      avail_q    <= '0;
      ncl_q      <= '0;
      bc_q       <= '0;
    end else if (fire) begin
      fetching_q <= 1'b1;
      head_q     <= '0;
      avail_q    <= '0;
      ncl_q      <= nc_s;
      bc_q       <= '0;
    end else begin
      if (rd_rvalid && fetching_q) begin
        if (last_beat) begin
          fetching_q <= 1'b0;
          avail_q    <= ncl_q;
        end else begin
          bc_q <= bc_q + LW'(1);
        end
      end
      if (close) head_q <= head_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      off_q  <= '0;
      mid_q  <= 1'b0;
      tk_q   <= 1'b0;
      drop_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      irq_q <= close && ca_int[cur];
      if (store) off_q <= (fill || rx_last) ? '0 : off_q + 11'd1;
      if (close) prod_q <= (prod_q == ring_cnt - IW'(1)) ? '0 : prod_q + IW'(1);
      if (rx_valid) begin
        mid_q  <= !rx_last;
        tk_q   <= (start || tk_q) && !rx_last;
        drop_q <= (drop_q || lose) && !rx_last;
      end
      if (lose) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_frag_dma_chk.sv
module rx_frag_dma_chk #(
  parameter int IW = 4,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [IW-1:0] ring_cnt,
  input logic [IW-1:0] cons_idx,
  input logic          ovr_clr,
  input logic          rd_req,
  input logic [LW-1:0] rd_len,
  input logic          st_cmd,
  input logic [LW-1:0] st_cmd_len,
  input logic          dw_valid,
  input logic          st_we,
  input logic [IW-1:0] prod_idx,
  input logic          irq,
  input logic          overrun
);

  p_fetch_pairs_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> st_cmd && (32'(rd_len) == 2 * 32'(st_cmd_len) + 1));

  p_no_fetch_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rd_req);

  p_no_fetch_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> prod_idx != ((cons_idx == '0) ? ring_cnt - IW'(1) : cons_idx - IW'(1)));

  p_status_with_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> dw_valid);

  p_prod_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> prod_idx == (($past(prod_idx) == $past(ring_cnt) - IW'(1)) ? '0
                           : $past(prod_idx) + IW'(1)));

  p_prod_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> $stable(prod_idx));

  p_irq_after_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(st_we));

  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

endmodule

bind rx_frag_dma rx_frag_dma_chk #(.IW(IW), .LW(LW)) u_chk (.*);

// File: tb/rx_frag_dma_test.sv
`timescale 1ns/1ps
module rx_frag_dma_test;
  localparam int IW = 4;
  localparam int LW = 3;
  localparam int GAP = 16;

  logic clk = 0, rst_n = 0, en = 0, ovr_clr = 0;
  logic [31:0] desc_base = 32'h100, stat_base = 32'h400;
  logic [IW-1:0] ring_cnt = 4, cons_idx = 0;
  logic rx_valid = 0, rx_last = 0;
  logic [7:0] rx_byte = 0;
  logic rd_req, st_cmd, dw_valid, st_we, irq, overrun;
  logic [31:0] rd_addr, st_cmd_addr, dw_addr, st_addr, st_data;
  logic [LW-1:0] rd_len, st_cmd_len;
  logic [7:0] dw_byte;
  logic [IW-1:0] prod_idx;
  logic rd_rvalid = 0;
  logic [31:0] rd_rdata = 0;

  always #10 clk = ~clk;

  rx_frag_dma uut (.*);

  logic [31:0] dadr [0:15];
  logic [31:0] dctl [0:15];
  logic [7:0]  dmem [0:1023];
  logic [31:0] sa [0:31];
  logic [31:0] sd [0:31];
  int ns = 0, ndw = 0, nrd = 0, nirq = 0, rb_left = 0;
  logic [31:0] rb_addr, last_rd_addr, last_sc_addr;
  logic [LW-1:0] last_rd_len, last_sc_len;
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] dword(input logic [31:0] a);
    int idx;
    idx = int'((a - 32'h100) >> 3);
    return a[2] ? dctl[idx] : dadr[idx];
  endfunction

  always @(posedge clk) begin
    rd_rvalid <= 1'b0;
    if (rd_req) begin
      rb_addr = rd_addr; rb_left = int'(rd_len) + 1; nrd++;
      last_rd_addr = rd_addr; last_rd_len = rd_len;
    end else if (rb_left > 0) begin
      rd_rvalid <= 1'b1;
      rd_rdata  <= dword(rb_addr);
      rb_addr = rb_addr + 4; rb_left--;
    end
    if (st_cmd) begin last_sc_addr = st_cmd_addr; last_sc_len = st_cmd_len; end
    if (dw_valid) begin dmem[(dw_addr - 32'h1000) & 32'h3ff] = dw_byte; ndw++; end
    if (st_we) begin sa[ns] = st_addr; sd[ns] = st_data; ns++; end
    if (irq) nirq++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_byte = seed + 8'(i); rx_last = (i == len - 1);
      @(negedge clk);
      rx_valid = 0; rx_last = 0;
      repeat (GAP) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 prod", prod_idx, 0);
    chk("R1 irq", irq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 outputs", {rd_req, dw_valid, st_we, st_cmd}, 0);
  endtask

  task automatic t_enable_midframe;
    @(negedge clk); rx_valid = 1; rx_byte = 8'hAA; rx_last = 0;
    @(negedge clk); rx_valid = 0;
    repeat (20) @(negedge clk);
    chk("R10 no fetch while off", nrd, 0);
    en = 1;
    send_frame(4, 8'hB0);
    chk("R10 frame in progress dropped", ndw, 0);
    chk("R10 no status", ns, 0);
    chk("R2 fetch count", nrd, 1);
    chk("R2 fetch addr", last_rd_addr, 32'h100);
    chk("R2 fetch len", last_rd_len, 5);
    chk("R3 status cmd addr", last_sc_addr, 32'h400);
    chk("R3 status cmd len", last_sc_len, 2);
  endtask

  task automatic t_multi_fragment;
    send_frame(19, 8'h20);
    chk("R6 status count", ns, 3);
    chk("R7 addr 0", sa[0], 32'h400);
    chk("R7 addr 1", sa[1], 32'h404);
    chk("R7 addr 2", sa[2], 32'h408);
    chk("R5 status 0", sd[0], 32'h7);
    chk("R5 status 1", sd[1], 32'h7);
    chk("R6 status 2", sd[2], 32'h80000002);
    chk("R4 byte 0", dmem[0], 8'h20);
    chk("R4 byte 7", dmem[7], 8'h27);
    chk("R4 byte 8", dmem[12'h100], 8'h28);
    chk("R4 byte 18", dmem[12'h202], 8'h32);
    chk("R4 byte count", ndw, 19);
    chk("R9 irq count", nirq, 1);
    chk("R8 prod", prod_idx, 3);
    chk("R13 ring full, no fetch", nrd, 1);
  endtask

  task automatic t_overrun;
    dctl[0] = 32'h0;
    dctl[1] = 32'h80000007;
    send_frame(5, 8'h50);
    chk("R11 bytes dropped", ndw, 19);
    chk("R11 overrun set", overrun, 1);
    repeat (10) @(negedge clk);
    chk("R11 overrun sticky", overrun, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0; @(negedge clk);
    chk("R11 overrun cleared", overrun, 0);
  endtask

  task automatic t_boundary_and_wrap;
    cons_idx = 3;
    repeat (20) @(negedge clk);
    chk("R13 fetch after consume", nrd, 2);
    chk("R2 fetch addr at end", last_rd_addr, 32'h118);
    chk("R2 fetch len at end", last_rd_len, 1);
    chk("R3 status cmd at end", last_sc_addr, 32'h40C);
    chk("R3 status len at end", last_sc_len, 0);
    send_frame(8, 8'h40);
    chk("R12 one status", ns, 4);
    chk("R12 boundary status", sd[3], 32'h80000007);
    chk("R7 boundary addr", sa[3], 32'h40C);
    chk("R8 wrap", prod_idx, 0);
    chk("R4 last byte", dmem[12'h307], 8'h47);
    chk("R2 refetch count", nrd, 3);
    chk("R2 refetch addr", last_rd_addr, 32'h100);
    chk("R2 refetch len", last_rd_len, 3);
  endtask

  task automatic t_tiny_fragment;
    send_frame(3, 8'h60);
    chk("R12 status count", ns, 6);
    chk("R12 one-byte frag", sd[4], 32'h0);
    chk("R6 final frag", sd[5], 32'h80000001);
    chk("R7 addr", sa[5], 32'h404);
    chk("R12 byte 0", dmem[0], 8'h60);
    chk("R5 continue next buf", dmem[12'h100], 8'h61);
    chk("R4 byte 2", dmem[12'h101], 8'h62);
    chk("R9 irq count", nirq, 2);
    chk("R8 prod", prod_idx, 2);
    chk("R13 full again", nrd, 3);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      dadr[i] = 32'h1000 + 32'(i) * 32'h100;
      dctl[i] = 32'h7;
    end
    dctl[2] = 32'h80000007;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_enable_midframe;
    t_multi_fragment;
    t_overrun;
    t_boundary_and_wrap;
    t_tiny_fragment;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule